// File: doc/BRIEF.md
# Single-Wire Pulse-Count Dimming Decoder

This block turns one control pin into the enable and brightness code of a white-LED boost driver. The pin is sampled on a local clock. The block measures how long the pin stays high and how long it stays low, and sorts each interval into one of four cases: an enable request, a dimming step, a shutdown, or nothing at all.

The brightness is a 5-bit code with 32 linear steps. Code n asks for (n+1)/32 of full-scale current, so code 31 is full scale and code 0 is 1/32. Each step is one 1/32 of full scale.

A separate overvoltage input stops the driver and holds it off. That latch is cleared only by a long low time on the pin. All time thresholds are parameters counted in clock cycles.

The pin passes through a two-stage synchronizer. Because of this, a change on the pin reaches the outputs on the third rising clock edge after the first edge that samples the new pin value. The overvoltage input is taken as already synchronous to the clock.

Top module: `led_dim_decoder`

## Requirements
- R1: Reset holds `drv_en` at 0 and `level` at 31. Code 31 means full scale, and code n means (n+1)/32 of full-scale current.
- R2: While the driver is disabled and no fault is latched, the pin held high for at least EN_CYC cycles sets `drv_en` to 1 and `level` to 31. A high time shorter than EN_CYC leaves the driver disabled.
- R3: While the driver is enabled, a low pulse of PULSE_MIN_CYC to PULSE_MAX_CYC cycles, both limits included, lowers `level` by exactly one code. The change is made when the pin returns high.
- R4: While the driver is enabled, a low pulse shorter than PULSE_MIN_CYC cycles leaves `level` and `drv_en` unchanged.
- R5: While the driver is enabled, a low time longer than PULSE_MAX_CYC and shorter than OFF_CYC cycles leaves `level` and `drv_en` unchanged.
- R6: The pin held low for OFF_CYC cycles or more clears `drv_en`. This happens while the pin is still low.
- R7: A valid step pulse received at code 0 sets `level` back to 31.
- R8: While the driver is disabled, low pulses of any width leave it disabled and do not alter `level`. A later enable always starts at code 31.
- R9: `ovp_fault` at 1 clears `drv_en` on the next clock and latches a fault. While the fault is latched, no pin activity re-enables the driver. Only a low time of at least OFF_CYC cycles clears the fault, and after that the pin must again be high for EN_CYC cycles to enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dim_pin | input | 1 | Asynchronous enable/dimming control pin |
| ovp_fault | input | 1 | Overvoltage detect, synchronous, active high |
| drv_en | output | 1 | Boost driver enable |
| level | output | 5 | Brightness code, 31 = full scale, 0 = 1/32 |

## Verification
The bench probes low pulses exactly at PULSE_MIN_CYC and PULSE_MAX_CYC, and one cycle outside each limit. An off-by-one comparison would either drop a legal step or count a glitch or a mid-length pulse as a step. It walks the level down through code 0 to catch a decoder that saturates instead of wrapping, or that wraps to the wrong code. It pulses the pin while the driver is disabled and then re-enables, which exposes a level carried over from before the shutdown. It also applies a low time one cycle short of OFF_CYC while a fault is latched, which shows a fault latch that clears too early or that pin activity can override.

// File: rtl/dim_pkg.sv
// Package dim_pkg
// Shared constants and the level type of the dimming decoder.
// Assumes the number of steps is at least two.
package dim_pkg;
    localparam int DIM_STEPS = 32;
    localparam int DIM_LW    = $clog2(DIM_STEPS);
    typedef logic [DIM_LW-1:0] dim_level_t;
    localparam dim_level_t DIM_FULL = dim_level_t'(DIM_STEPS - 1);
endpackage

// File: rtl/dim_sync.sv
// Module dim_sync
// Multi-stage synchronizer for one asynchronous input.
// Assumes STAGES >= 2 and resets to 0, which reads as a low pin.
module dim_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/dim_width_timer.sv
// Module dim_width_timer
// Measures how long the synchronized pin has held its present value and
// classifies the interval. Three signals come out:
//   step_ev   - a legal step pulse has just ended
//   low_long  - the pin has been low for the shutdown time
//   high_long - the pin has been high for the enable time
// Assumes PULSE_MIN_CYC <= PULSE_MAX_CYC < OFF_CYC.
// The run counter saturates at the larger of OFF_CYC and EN_CYC.
module dim_width_timer #(
    parameter int EN_CYC        = 12500,
    parameter int PULSE_MIN_CYC = 63,
    parameter int PULSE_MAX_CYC = 62500,
    parameter int OFF_CYC       = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    output logic step_ev,
    output logic low_long,
    output logic high_long
);
    localparam int SAT = (OFF_CYC > EN_CYC) ? OFF_CYC : EN_CYC;
    localparam int CW  = $clog2(SAT + 1);

    logic          s_d;
    logic [CW-1:0] run;

    // Track the previous sample and the length of its run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_d <= 1'b0;
            run <= '0;
        end else begin
            s_d <= s;
            if (s != s_d)               run <= CW'(1);
            else if (run != CW'(SAT))   run <= run + CW'(1);
        end
    end

    // Classify the finished or ongoing interval.
    always_comb begin
        step_ev   = s && !s_d && (run >= CW'(PULSE_MIN_CYC)) && (run <= CW'(PULSE_MAX_CYC));
        low_long  = !s_d && (run >= CW'(OFF_CYC));
        high_long = s_d && (run >= CW'(EN_CYC));
    end

    // R3, R5: a step and a shutdown never come from the same interval
    a_r5_step_not_off: assert property (@(posedge clk) disable iff (!rst_n)
        step_ev |-> !low_long);
endmodule

// File: rtl/dim_ctrl.sv
// Module dim_ctrl
// Enable, fault latch and brightness level of the dimming decoder.
// Priority, highest first:
//   1. overvoltage
//   2. fault clear
//   3. shutdown
//   4. enable
//   5. step
// Assumes the classifier inputs come from dim_width_timer.
module dim_ctrl
    import dim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovp,
    input  logic       step_ev,
    input  logic       low_long,
    input  logic       high_long,
    output logic       en,
    output dim_level_t level
);
    logic fault_q;

    // Update enable, fault and level from the classified pin events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            fault_q <= 1'b0;
            level   <= DIM_FULL;
        end else if (ovp) begin
            fault_q <= 1'b1;
            en      <= 1'b0;
        end else if (fault_q) begin
            if (low_long) fault_q <= 1'b0;
        end else if (low_long) begin
            en <= 1'b0;
        end else if (!en && high_long) begin
            en    <= 1'b1;
            level <= DIM_FULL;
        end else if (en && step_ev) begin
            level <= (level == '0) ? DIM_FULL : level - dim_level_t'(1);
        end
    end

    // R2: every enable starts at full scale
    a_r2_enable_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> level == DIM_FULL);

    // R3, R7: while enabled the level moves only by one step down, or wraps
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && level != $past(level)) |->
            ((level == $past(level) - dim_level_t'(1)) ||
             ($past(level) == '0 && level == DIM_FULL)));

    // R6: the driver turns off only on overvoltage or a long low time
    a_r6_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> ($past(ovp) || $past(low_long)));

    // R9: the fault latch clears only after a long low time
    a_r9_clear_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(low_long));
endmodule

// File: rtl/led_dim_decoder.sv
// Module led_dim_decoder
// Top of the single-wire dimming decoder. It wires together the
// synchronizer, the width timer and the control logic.
// Timing parameters are in clock cycles. The defaults assume a 125 MHz clock.
// ovp_fault is assumed synchronous to clk.
module led_dim_decoder
    import dim_pkg::*;
#(
    parameter int EN_CYC        = 12500,
    parameter int PULSE_MIN_CYC = 63,
    parameter int PULSE_MAX_CYC = 62500,
    parameter int OFF_CYC       = 250000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dim_pin,
    input  logic              ovp_fault,
    output logic              drv_en,
    output logic [DIM_LW-1:0] level
);
    logic pin_s;
    logic step_ev;
    logic low_long;
    logic high_long;

    dim_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dim_pin),
        .q     (pin_s)
    );

    dim_width_timer #(
        .EN_CYC        (EN_CYC),
        .PULSE_MIN_CYC (PULSE_MIN_CYC),
        .PULSE_MAX_CYC (PULSE_MAX_CYC),
        .OFF_CYC       (OFF_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .s         (pin_s),
        .step_ev   (step_ev),
        .low_long  (low_long),
        .high_long (high_long)
    );

    dim_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovp       (ovp_fault),
        .step_ev   (step_ev),
        .low_long  (low_long),
        .high_long (high_long),
        .en        (drv_en),
        .level     (level)
    );

    // R9: overvoltage turns the driver off on the next clock
    a_r9_ovp_off: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_fault |=> !drv_en);
endmodule

// File: tb/tb_led_dim_decoder.sv
module tb_led_dim_decoder;
    localparam int EN   = 30;
    localparam int PMIN = 4;
    localparam int PMAX = 40;
    localparam int OFF  = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dim_pin = 1'b0;
    logic       ovp_fault = 1'b0;
    logic       drv_en;
    logic [4:0] level;

    int    nchk = 0;
    int    nerr = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    led_dim_decoder #(
        .EN_CYC(EN), .PULSE_MIN_CYC(PMIN), .PULSE_MAX_CYC(PMAX), .OFF_CYC(OFF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dim_pin(dim_pin), .ovp_fault(ovp_fault),
        .drv_en(drv_en), .level(level)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: pin seen two clocks late; interval lengths kept as integers
    int p1, p2, mv, mlen, m_lvl;
    bit m_en, m_fault;
    always @(posedge clk) begin : model
        int  v;
        bit  lowl, highl, stp;
        if (!rst_n) begin
            p1 = 0; p2 = 0; mv = 0; mlen = 0;
            m_en = 0; m_fault = 0; m_lvl = 31;
        end else begin
            v = p2; p2 = p1; p1 = int'(dim_pin);
            lowl  = (mv == 0) && (mlen >= OFF);
            highl = (mv == 1) && (mlen >= EN);
            stp   = (v == 1) && (mv == 0) && (mlen >= PMIN) && (mlen <= PMAX);
            if (ovp_fault) begin
                m_fault = 1; m_en = 0;
            end else if (m_fault) begin
                if (lowl) m_fault = 0;
            end else if (lowl) begin
                m_en = 0;
            end else if (!m_en && highl) begin
                m_en = 1; m_lvl = 31;
            end else if (m_en && stp) begin
                m_lvl = (m_lvl == 0) ? 31 : m_lvl - 1;
            end
            if (v == mv) mlen++;
            else begin mv = v; mlen = 1; end
        end
    end

    // Compare against the model every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " model en"}, int'(drv_en), int'(m_en));
            check({cur_req, " model level"}, int'(level), m_lvl);
        end
    end

    task automatic hold(input logic val, input int n);
        for (int i = 0; i < n; i++) begin
            dim_pin = val;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int low_n, input int high_n);
        hold(1'b0, low_n);
        hold(1'b1, high_n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset en", int'(drv_en), 0);
        check("R1 reset level", int'(level), 31);

        cur_req = "R2";
        hold(1'b1, 20);
        hold(1'b0, 10);
        check("R2 short high no enable", int'(drv_en), 0);
        hold(1'b1, 40);
        check("R2 enable", int'(drv_en), 1);
        check("R2 full scale", int'(level), 31);

        cur_req = "R3";
        pulse(10, 10);
        check("R3 step", int'(level), 30);
        pulse(PMIN, 10);
        check("R3 min width step", int'(level), 29);
        pulse(PMAX, 10);
        check("R3 max width step", int'(level), 28);

        cur_req = "R4";
        pulse(PMIN - 1, 10);
        check("R4 glitch ignored", int'(level), 28);

        cur_req = "R5";
        pulse(PMAX + 1, 10);
        check("R5 mid low ignored", int'(level), 28);
        pulse(OFF - 1, 10);
        check("R5 just under off level", int'(level), 28);
        check("R5 just under off en", int'(drv_en), 1);

        cur_req = "R7";
        for (int i = 0; i < 28; i++) pulse(6, 6);
        check("R7 reached code 0", int'(level), 0);
        pulse(6, 6);
        check("R7 wrap to full", int'(level), 31);
        pulse(6, 6);
        check("R7 after wrap", int'(level), 30);

        cur_req = "R6";
        hold(1'b0, OFF + 4);
        check("R6 long low disables", int'(drv_en), 0);

        cur_req = "R8";
        hold(1'b1, 10);
        pulse(8, 10);
        check("R8 pulses while off en", int'(drv_en), 0);
        check("R8 pulses while off level", int'(level), 30);
        hold(1'b1, 40);
        check("R8 re-enable en", int'(drv_en), 1);
        check("R8 re-enable full", int'(level), 31);

        cur_req = "R9";
        ovp_fault = 1'b1;
        @(negedge clk);
        ovp_fault = 1'b0;
        check("R9 ovp off next clock", int'(drv_en), 0);
        hold(1'b1, 50);
        check("R9 high does not re-enable", int'(drv_en), 0);
        pulse(OFF - 1, 50);
        check("R9 short low keeps fault", int'(drv_en), 0);
        pulse(OFF, 50);
        check("R9 cleared then enabled", int'(drv_en), 1);
        check("R9 level after clear", int'(level), 31);

        hold(1'b0, 10);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule